// File: doc/BRIEF.md
# Sparse Address Decoder with Switchable Upper RAM

This block sits beside an 8-bit processor whose address bus is 16 bits wide. It turns each bus address into chip selects for a RAM, a boot ROM, a compact-flash window and four single-byte I/O registers. It also holds a one-bit bank selector, which drives the RAM's extra address line. The decode is sparse on purpose: the top four address lines and the bottom six are examined, and the six lines between them are not. As a result, every ROM and I/O location appears many times within the top 4 KB page.

Below that page, all of memory is RAM. The lowest 16 KB is always the same physical RAM. The span from 0x4000 up to 0xEFFF is served by one of two physical banks, chosen by the stored bank bit. Software writes the bank bit through one of the I/O register slots and reads it back through the same slot. Reset clears it, so the processor starts on bank 0. The other register selects (PS/2 line control, serial transmit data, serial status) are only decoded here. Their storage lives elsewhere.

Top module: `bus_window_decoder`

## Requirements
- R1: `ram_sel` is 1 for every address whose bits 15:12 are not all ones (0x0000–0xEFFF), and 0 for every address 0xF000–0xFFFF.
- R2: `rom_sel` is 1 exactly when address bits 15:12 are all ones and address bit 5 is 1 (for example 0xFFE0–0xFFFF).
- R3: `cf_sel` is 1 exactly when address bits 15:12 are all ones and address bits 5:4 are 00 (for example 0xF000–0xF00F).
- R4: Within the top page, the register selects decode address bits 5:0 as follows: 010010 gives `bank_reg_sel`, 010100 gives `ps2_ctl_sel`, 011001 gives `ser_tx_sel` and 011000 gives `ser_stat_sel`. Any other 01xxxx value asserts no select.
- R5: Address bits 11:6 never change any select. An address and each of its aliases that differ only in those bits decode the same way.
- R6: For every address, at most one of `ram_sel`, `rom_sel`, `cf_sel`, `bank_reg_sel`, `ps2_ctl_sel`, `ser_tx_sel`, `ser_stat_sel` is 1.
- R7: On a rising clock edge where `wr_en` is 1 and the address decodes to the bank register, the bank bit takes `wdata[0]`. `wdata[7:1]` have no effect.
- R8: While `rst_n` is low, and after it is released, the bank bit is 0 until the first write.
- R9: `ram_bank_line` equals the bank bit when `ram_sel` is 1 and the address is 0x4000–0xEFFF. It is 0 for addresses 0x0000–0x3FFF and for any address where `ram_sel` is 0.
- R10: When `rd_en` is 1 and the address decodes to the bank register, `rdata` is {7'b0, bank bit}. In every other case `rdata` is 0x00.
- R11: The bank bit does not change on a write to any other address, or at the bank address while `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write data |
| rd_en | input | 1 | Read strobe for the current cycle |
| wr_en | input | 1 | Write strobe, captured on the rising clock edge |
| ram_sel | output | 1 | RAM chip select |
| ram_bank_line | output | 1 | Extra RAM address line (bank) |
| rom_sel | output | 1 | ROM chip select |
| cf_sel | output | 1 | Compact-flash window select |
| bank_reg_sel | output | 1 | Bank register slot select |
| ps2_ctl_sel | output | 1 | PS/2 control register select |
| ser_tx_sel | output | 1 | Serial transmit data register select |
| ser_stat_sel | output | 1 | Serial status register select |
| rdata | output | 8 | Read data from the bank register slot |

## Verification
The decoder holds exactly one bit of state, the bank selector. A wrong value in it shows in two places. It appears on `ram_bank_line` as soon as an access lands in 0x4000–0xEFFF. It also appears on `rdata[0]` when the bank slot is read in the same cycle. A write that is lost, or that is taken from the wrong data bit, therefore shows on the first upper-RAM access or readback after the write edge. A corrupt select path shows in the cycle the address is applied, either as two selects active together or as a select that differs between two aliases of the same location.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 4;
  localparam int SLOT_W = 6;

  localparam logic [SLOT_W-1:0] SLOT_BANK = 6'b010010;
  localparam logic [SLOT_W-1:0] SLOT_PS2  = 6'b010100;
  localparam logic [SLOT_W-1:0] SLOT_TXD  = 6'b011001;
  localparam logic [SLOT_W-1:0] SLOT_STAT = 6'b011000;

  // first page number served by the switchable RAM banks
  localparam logic [PAGE_W-1:0] BANKED_FIRST_PAGE = 4'h4;

  typedef struct packed {
    logic ram;
    logic rom;
    logic cf;
    logic bank;
    logic ps2;
    logic txd;
    logic stat;
  } sel_t;

  localparam int SEL_N = $bits(sel_t);

endpackage

// File: rtl/bwd_rst_sync.sv
module bwd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bwd_region_decode.sv
module bwd_region_decode
  import bwd_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output sel_t          sel,
  output logic          banked_span
);

  localparam int PAGE_LSB = AW - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic [SLOT_W-1:0] slot;
  logic              io_page;
  logic              reg_group;

  always_comb begin
    page      = addr[AW-1:PAGE_LSB];
    slot      = addr[SLOT_W-1:0];
    io_page   = &page;
    reg_group = (slot[SLOT_W-1 -: 2] == 2'b01);

    sel       = '0;
    sel.ram   = !io_page;
    sel.rom   = io_page && slot[SLOT_W-1];
    sel.cf    = io_page && (slot[SLOT_W-1 -: 2] == 2'b00);
    sel.bank  = io_page && reg_group && (slot == SLOT_BANK);
    sel.ps2   = io_page && reg_group && (slot == SLOT_PS2);
    sel.txd   = io_page && reg_group && (slot == SLOT_TXD);
    sel.stat  = io_page && reg_group && (slot == SLOT_STAT);

    banked_span = !io_page && (page >= BANKED_FIRST_PAGE);
  end

endmodule

// File: rtl/bwd_bank_reg.sv
module bwd_bank_reg
  import bwd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_sync_n,
  input  logic          hit,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic          bank_q,
  output logic [DW-1:0] rdata
);

  logic load_en;
  logic bank_d;

  always_comb begin
    load_en = hit && wr_en;
    bank_d  = load_en ? wdata[0] : bank_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bank_q <= 1'b0;
    end else if (load_en) begin
      bank_q <= bank_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit && rd_en) begin
      rdata[0] = bank_q;
    end
  end

  // R7: a qualified write lands data bit 0 on the next cycle
  p_bank_load_r7 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && wr_en) |=> (bank_q == $past(wdata[0])));

  // R11: without a qualified write the stored bit holds
  p_bank_hold_r11 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hit && wr_en) |=> $stable(bank_q));

  // R10: upper read bits are always zero
  p_rdata_upper_r10 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    rdata[DW-1:1] == '0);

endmodule

// File: rtl/bus_window_decoder.sv
module bus_window_decoder
  import bwd_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int DW         = DATA_W,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic          wr_en,
  output logic          ram_sel,
  output logic          ram_bank_line,
  output logic          rom_sel,
  output logic          cf_sel,
  output logic          bank_reg_sel,
  output logic          ps2_ctl_sel,
  output logic          ser_tx_sel,
  output logic          ser_stat_sel,
  output logic [DW-1:0] rdata
);

  logic             rst_sync_n;
  sel_t             sel;
  logic             banked_span;
  logic             bank_q;
  logic [SEL_N-1:0] sel_vec;

  bwd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bwd_region_decode #(.AW(AW)) u_dec (
    .addr        (addr),
    .sel         (sel),
    .banked_span (banked_span)
  );

  bwd_bank_reg #(.DW(DW)) u_bank (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .hit        (sel.bank),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .bank_q     (bank_q),
    .rdata      (rdata)
  );

  always_comb begin
    sel_vec       = sel;
    ram_sel       = sel.ram;
    rom_sel       = sel.rom;
    cf_sel        = sel.cf;
    bank_reg_sel  = sel.bank;
    ps2_ctl_sel   = sel.ps2;
    ser_tx_sel    = sel.txd;
    ser_stat_sel  = sel.stat;
    ram_bank_line = sel.ram && banked_span && bank_q;
  end

  // R6: never two selects at once
  p_sel_exclusive_r6 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(sel_vec));

  // R1: the top page never reaches the RAM
  p_no_ram_top_page_r1 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&addr[AW-1 -: PAGE_W]) |-> !ram_sel);

  // R9: the common low region always uses bank 0
  p_common_bank0_r9 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr[AW-1 -: 2] == 2'b00) |-> !ram_bank_line);

  // R9: the bank line only ever accompanies a RAM access
  p_bank_line_needs_ram_r9 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_bank_line |-> ram_sel);

endmodule

// File: tb/bus_window_decoder_tb_top.sv
module bus_window_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rd_en;
  logic        wr_en;
  logic        ram_sel, ram_bank_line, rom_sel, cf_sel;
  logic        bank_reg_sel, ps2_ctl_sel, ser_tx_sel, ser_stat_sel;
  logic [7:0]  rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bus_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en),
    .ram_sel(ram_sel), .ram_bank_line(ram_bank_line),
    .rom_sel(rom_sel), .cf_sel(cf_sel), .bank_reg_sel(bank_reg_sel),
    .ps2_ctl_sel(ps2_ctl_sel), .ser_tx_sel(ser_tx_sel),
    .ser_stat_sel(ser_stat_sel), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  // 7-bit select vector: ram rom cf bank ps2 txd stat
  function automatic logic [6:0] sels();
    return {ram_sel, rom_sel, cf_sel, bank_reg_sel, ps2_ctl_sel, ser_tx_sel, ser_stat_sel};
  endfunction

  function automatic logic [6:0] model_sels(input logic [15:0] a);
    logic top = (a[15:12] == 4'hF);
    logic [5:0] s = a[5:0];
    return {!top, top && s[5], top && (s[5:4] == 2'b00),
            top && s == 6'b010010, top && s == 6'b010100,
            top && s == 6'b011001, top && s == 6'b011000};
  endfunction

  task automatic apply_addr(input logic [15:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit we);
    @(negedge clk);
    addr = a; wdata = d; wr_en = we;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic read_bank(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    apply_addr(16'h4000);
    check(ram_bank_line == 1'b0, "R8 bank line after reset", ram_bank_line, 0);
    read_bank(16'hFF12, v);
    check(v == 8'h00, "R8 readback after reset", v, 0);
  endtask

  task automatic t_ram_span();
    logic [15:0] pts [5] = '{16'h0000, 16'h3FFF, 16'h4000, 16'hEFFF, 16'h9A5C};
    foreach (pts[i]) begin
      apply_addr(pts[i]);
      check(sels() == 7'b1000000, "R1 ram span", sels(), 7'b1000000);
    end
    apply_addr(16'hF000);
    check(ram_sel == 1'b0, "R1 top page not ram", ram_sel, 0);
  endtask

  task automatic t_rom_cf();
    apply_addr(16'hFFE0); check(sels() == 7'b0100000, "R2 rom low", sels(), 7'b0100000);
    apply_addr(16'hFFFF); check(sels() == 7'b0100000, "R2 rom high", sels(), 7'b0100000);
    apply_addr(16'hF020); check(rom_sel == 1'b1, "R2 rom alias", rom_sel, 1);
    apply_addr(16'hF000); check(sels() == 7'b0010000, "R3 cf base", sels(), 7'b0010000);
    apply_addr(16'hF007); check(cf_sel == 1'b1, "R3 cf 7", cf_sel, 1);
    apply_addr(16'hFFCF); check(cf_sel == 1'b1, "R3 cf alias", cf_sel, 1);
  endtask

  task automatic t_reg_slots();
    apply_addr(16'hFF12); check(sels() == 7'b0001000, "R4 bank slot", sels(), 7'b0001000);
    apply_addr(16'hFF14); check(sels() == 7'b0000100, "R4 ps2 slot", sels(), 7'b0000100);
    apply_addr(16'hFF19); check(sels() == 7'b0000010, "R4 txd slot", sels(), 7'b0000010);
    apply_addr(16'hFF18); check(sels() == 7'b0000001, "R4 stat slot", sels(), 7'b0000001);
    apply_addr(16'hFF10); check(sels() == 7'b0000000, "R4 empty slot", sels(), 0);
    apply_addr(16'hFF1F); check(sels() == 7'b0000000, "R4 empty slot 1F", sels(), 0);
  endtask

  task automatic t_alias_sweep();
    int bad = 0;
    int multi = 0;
    logic [6:0] first;
    logic [6:0] exp;
    for (int lo = 0; lo < 64; lo++) begin
      apply_addr({4'hF, 6'd0, lo[5:0]});
      first = sels();
      exp = model_sels({4'hF, 6'd0, lo[5:0]});
      if (first != exp) bad++;
      if ($countones(first) > 1) multi++;
      for (int mid = 1; mid < 64; mid += 13) begin
        apply_addr({4'hF, mid[5:0], lo[5:0]});
        if (sels() != first) bad++;
      end
    end
    check(bad == 0, "R5 alias sweep mismatches", bad, 0);
    check(multi == 0, "R6 multiple selects", multi, 0);
  endtask

  task automatic t_bank_write();
    logic [7:0] v;
    bus_write(16'hFF12, 8'hFE, 1'b1);
    apply_addr(16'h4000);
    check(ram_bank_line == 1'b0, "R7 upper bits ignored", ram_bank_line, 0);
    bus_write(16'hFF12, 8'h01, 1'b1);
    apply_addr(16'h4000);
    check(ram_bank_line == 1'b1, "R9 bank 1 at 4000", ram_bank_line, 1);
    apply_addr(16'hEFFF);
    check(ram_bank_line == 1'b1, "R9 bank 1 at EFFF", ram_bank_line, 1);
    apply_addr(16'h3FFF);
    check(ram_bank_line == 1'b0, "R9 common region", ram_bank_line, 0);
    apply_addr(16'hFFE0);
    check(ram_bank_line == 1'b0, "R9 no ram no bank line", ram_bank_line, 0);
    read_bank(16'hFF12, v);
    check(v == 8'h01, "R10 readback", v, 1);
    read_bank(16'hF7D2, v);
    check(v == 8'h01, "R10 alias readback", v, 1);
    @(negedge clk); addr = 16'hFF12; rd_en = 1'b0; #1;
    check(rdata == 8'h00, "R10 no strobe", rdata, 0);
    read_bank(16'hFF14, v);
    check(v == 8'h00, "R10 other slot", v, 0);
  endtask

  task automatic t_ignored_writes();
    logic [7:0] v;
    bus_write(16'hFF14, 8'h00, 1'b1);
    bus_write(16'h4000, 8'h00, 1'b1);
    read_bank(16'hFF12, v);
    check(v == 8'h01, "R11 other address write", v, 1);
    bus_write(16'hFF12, 8'h00, 1'b0);
    read_bank(16'hFF12, v);
    check(v == 8'h01, "R11 no write strobe", v, 1);
    bus_write(16'hF392, 8'h00, 1'b1);
    read_bank(16'hFF12, v);
    check(v == 8'h00, "R7 alias write clears", v, 0);
    bus_write(16'hFF12, 8'h01, 1'b1);
    do_reset();
    read_bank(16'hFF12, v);
    check(v == 8'h00, "R8 reset clears bank", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; rd_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_ram_span();
    t_rom_cf();
    t_reg_slots();
    t_alias_sweep();
    t_bank_write();
    t_ignored_writes();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule